// File: doc/BRIEF.md
# External Interrupt and Event Line Controller

This block watches sixteen input lines and turns selected signal edges into interrupt requests and event pulses. Each line n is wired to pin n of one of several ports, and a small field per line picks the port. Every pin is first brought into the block clock domain. The chosen sample is then compared with the one from the previous cycle to find rising and falling edges.

Each line has four enable bits: a rising-trigger enable, a falling-trigger enable, an interrupt enable and an event enable. When an enabled edge is seen and the interrupt enable is set, a sticky pending bit is raised. The pending bit stays set until software writes a one to it. The interrupt request of a line is its pending bit gated by its interrupt enable. When the event enable is set, an enabled edge gives a single-cycle event pulse instead of, or as well as, the pending bit. Software can also fire lines directly through a trigger register.

Configuration goes through a plain register bus. A write is accepted on any clock edge where the write strobe is high. Reads return the addressed register combinationally.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, all enable registers, all select registers and the pending register read 0, and irq_o and evt_o are 0.
- R2: With the rising enable (address 2, bit n) and the interrupt enable (address 0, bit n) set, a 0-to-1 change on the selected pin sets pending bit n and irq_o[n] right after the third rising clock edge that follows the change, and not before.
- R3: A falling edge triggers only when the falling enable (address 3, bit n) is set. A rising edge triggers only when the rising enable is set. With both set, both edges trigger. With neither set, no edge has an effect.
- R4: An edge on a line whose interrupt enable is 0 does not set its pending bit (address 4 reads 0 there). Setting the enable later does not recover that edge.
- R5: With the event enable (address 1, bit n) set, an enabled edge drives evt_o[n] high for exactly one clock cycle, in the same cycle that irq_o[n] would rise. Without the interrupt enable, the pending bit stays 0.
- R6: Writing address 4 clears each pending bit whose data bit is 1. Bits written as 0 are unchanged.
- R7: When an enabled edge sets a pending bit in the same cycle that a clear write targets it, the bit stays set.
- R8: Writing 1 to bit n of address 5 sets pending bit n if its interrupt enable is set. It pulses evt_o[n] for one cycle, starting right after the write edge, if its event enable is set. Address 5 reads 0.
- R9: The source of line n is the 4-bit field at bits 4*(n&3) of select register 8+(n>>2). Line n follows only pin n of that port, which is port_pins bit port*16+n. A field value of 7 or more gives a constant 0.
- R10: Writing a line's select field causes no edge by itself, even when the old and new sources differ in level. Later edges of the new source are detected normally.
- R11: Enable and select registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_pins | input | 112 | Asynchronous pin inputs; port p pin n at bit p*16+n |
| bus_we | input | 1 | Register write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq_o | output | 16 | Per-line interrupt request: pending AND interrupt enable |
| evt_o | output | 16 | Per-line single-cycle event pulse |

## Verification
A pin change is due at irq_o, evt_o and the pending register after the third rising edge. Two of those edges are synchronizer stages and one is the pending or event register. The bench therefore checks one edge earlier for absence and exactly at the third edge for presence.

Bus-driven results are due one edge after the write strobe: software triggers, clears and register contents. The clear-versus-edge race is built by putting the clear strobe on the very edge where the synchronized edge is registered.

Event pulses are checked high in their due cycle and low one cycle later. Checks of suppressed behaviour wait at least five edges before looking at the outputs and the pending register.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
// Shared constants of the external line controller: register word
// addresses and the select-register packing.
package extint_pkg;
    localparam int ADDR_W = 4;
    localparam int FIELDS_PER_SEL = 4;

    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 4'd0;
    localparam logic [ADDR_W-1:0] A_EVT_EN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_RISE     = 4'd2;
    localparam logic [ADDR_W-1:0] A_FALL     = 4'd3;
    localparam logic [ADDR_W-1:0] A_PEND     = 4'd4;
    localparam logic [ADDR_W-1:0] A_SWTRIG   = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 4'd8;
endpackage

// File: rtl/extint_regs.sv
`timescale 1ns/1ps
// Register file of the line controller.
// Holds the four per-line enable masks and the packed source-select fields.
// Decodes clear and software-trigger strobes, and serves combinational reads.
// Assumes BUS_W covers both NUM_LINES and one full select register.
// A write is taken on any clock edge with bus_we high.
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int SEL_W     = 4,
    parameter int BUS_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic [NUM_LINES-1:0]       pend,
    output logic [NUM_LINES-1:0]       irq_en,
    output logic [NUM_LINES-1:0]       evt_en,
    output logic [NUM_LINES-1:0]       rise_en,
    output logic [NUM_LINES-1:0]       fall_en,
    output logic [NUM_LINES*SEL_W-1:0] sel_q,
    output logic [NUM_LINES*SEL_W-1:0] sel_d,
    output logic [NUM_LINES-1:0]       sw_hit,
    output logic [NUM_LINES-1:0]       clr_hit
);
    localparam int NUM_SEL = NUM_LINES / FIELDS_PER_SEL;
    localparam int REG_SW  = FIELDS_PER_SEL * SEL_W;

    // Next value of the select fields, seen by the sample-reload path this cycle.
    always_comb begin
        sel_d = sel_q;
        for (int r = 0; r < NUM_SEL; r++) begin
            if (bus_we && bus_addr == A_SEL_BASE + ADDR_W'(r))
                sel_d[r*REG_SW +: REG_SW] = bus_wdata[REG_SW-1:0];
        end
    end

    // Storage of the enable masks and select fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en  <= '0;
            evt_en  <= '0;
            rise_en <= '0;
            fall_en <= '0;
            sel_q   <= '0;
        end else begin
            sel_q <= sel_d;
            if (bus_we) begin
                case (bus_addr)
                    A_IRQ_EN: irq_en  <= bus_wdata[NUM_LINES-1:0];
                    A_EVT_EN: evt_en  <= bus_wdata[NUM_LINES-1:0];
                    A_RISE:   rise_en <= bus_wdata[NUM_LINES-1:0];
                    A_FALL:   fall_en <= bus_wdata[NUM_LINES-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Strobes for write-one-to-clear and software trigger.
    always_comb begin
        clr_hit = (bus_we && bus_addr == A_PEND)   ? bus_wdata[NUM_LINES-1:0] : '0;
        sw_hit  = (bus_we && bus_addr == A_SWTRIG) ? bus_wdata[NUM_LINES-1:0] : '0;
    end

    // Read multiplexer; the trigger register and unmapped words read 0.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_IRQ_EN: bus_rdata = BUS_W'(irq_en);
            A_EVT_EN: bus_rdata = BUS_W'(evt_en);
            A_RISE:   bus_rdata = BUS_W'(rise_en);
            A_FALL:   bus_rdata = BUS_W'(fall_en);
            A_PEND:   bus_rdata = BUS_W'(pend);
            default: ;
        endcase
        for (int r = 0; r < NUM_SEL; r++) begin
            if (bus_addr == A_SEL_BASE + ADDR_W'(r))
                bus_rdata = BUS_W'(sel_q[r*REG_SW +: REG_SW]);
        end
    end
endmodule

// File: rtl/extint_srcmux.sv
`timescale 1ns/1ps
// Per-line source multiplexer.
// Line n takes pin n of the port named by its select field.
// A field naming a port that does not exist yields 0.
// Assumes pins are packed port-major: port p pin n at bit p*NUM_LINES+n.
module extint_srcmux #(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 7,
    parameter int SEL_W     = 4
) (
    input  logic [NUM_PORTS*NUM_LINES-1:0] pins,
    input  logic [NUM_LINES*SEL_W-1:0]     sel,
    output logic [NUM_LINES-1:0]           smp
);
    // One-hot match of each select field against every existing port.
    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            smp[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel[n*SEL_W +: SEL_W] == SEL_W'(p))
                    smp[n] = smp[n] | pins[p*NUM_LINES + n];
            end
        end
    end
endmodule

// File: rtl/extint_line.sv
`timescale 1ns/1ps
// One line: edge detection, sticky pending bit and single-cycle event pulse.
// smp_now is the synchronized sample through the current select.
// smp_next is the same sample through the select of the next cycle.
// The previous-sample register loads smp_next, so a select change never
// looks like an edge. Setting the pending bit wins over a same-cycle clear.
module extint_line (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_now,
    input  logic smp_next,
    input  logic rise_en,
    input  logic fall_en,
    input  logic irq_en,
    input  logic evt_en,
    input  logic sw_hit,
    input  logic clr_hit,
    output logic pend_o,
    output logic evt_o
);
    logic prev_q;
    logic pend_q;
    logic evt_q;
    logic trig;
    logic set_pend;

    // Enabled edge or software trigger, and its effect on the pending bit.
    always_comb begin
        trig     = (rise_en & smp_now & ~prev_q) | (fall_en & ~smp_now & prev_q);
        set_pend = (trig | sw_hit) & irq_en;
    end

    // Previous sample, pending bit and event pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= smp_next;
            pend_q <= set_pend | (pend_q & ~clr_hit);
            evt_q  <= (trig | sw_hit) & evt_en;
        end
    end

    assign pend_o = pend_q;
    assign evt_o  = evt_q;

    // R4
    pend_needs_irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(irq_en));

    // R6
    pend_drop_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(clr_hit));

    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && sw_hit && irq_en) |=> pend_q);

    // R3
    evt_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(sw_hit || rise_en || fall_en));
endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/1ps
// Top of the external interrupt and event line controller.
// Synchronizes every pin with two flops, then selects one pin per line
// through the current and next select values. It instantiates one edge and
// pending slice per line, and gates the requests with the interrupt enables.
// Assumes port_pins are asynchronous levels and the bus is in the clk domain.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 7,
    parameter int SEL_W     = 4,
    localparam int BUS_W    = (NUM_LINES > FIELDS_PER_SEL*SEL_W) ? NUM_LINES : FIELDS_PER_SEL*SEL_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [BUS_W-1:0]               bus_wdata,
    output logic [BUS_W-1:0]               bus_rdata,
    output logic [NUM_LINES-1:0]           irq_o,
    output logic [NUM_LINES-1:0]           evt_o
);
    localparam int PIN_W = NUM_PORTS * NUM_LINES;

    logic [PIN_W-1:0]           sync1_q;
    logic [PIN_W-1:0]           sync2_q;
    logic [NUM_LINES-1:0]       irq_en, evt_en, rise_en, fall_en;
    logic [NUM_LINES-1:0]       sw_hit, clr_hit, pend;
    logic [NUM_LINES-1:0]       smp_now, smp_next;
    logic [NUM_LINES*SEL_W-1:0] sel_q, sel_d;

    // Two-flop synchronizer on every pin of every port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= port_pins;
            sync2_q <= sync1_q;
        end
    end

    extint_regs #(
        .NUM_LINES (NUM_LINES),
        .SEL_W     (SEL_W),
        .BUS_W     (BUS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend),
        .irq_en    (irq_en),
        .evt_en    (evt_en),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .sel_q     (sel_q),
        .sel_d     (sel_d),
        .sw_hit    (sw_hit),
        .clr_hit   (clr_hit)
    );

    extint_srcmux #(
        .NUM_LINES (NUM_LINES),
        .NUM_PORTS (NUM_PORTS),
        .SEL_W     (SEL_W)
    ) u_mux_now (
        .pins (sync2_q),
        .sel  (sel_q),
        .smp  (smp_now)
    );

    extint_srcmux #(
        .NUM_LINES (NUM_LINES),
        .NUM_PORTS (NUM_PORTS),
        .SEL_W     (SEL_W)
    ) u_mux_next (
        .pins (sync2_q),
        .sel  (sel_d),
        .smp  (smp_next)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        extint_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_now  (smp_now[n]),
            .smp_next (smp_next[n]),
            .rise_en  (rise_en[n]),
            .fall_en  (fall_en[n]),
            .irq_en   (irq_en[n]),
            .evt_en   (evt_en[n]),
            .sw_hit   (sw_hit[n]),
            .clr_hit  (clr_hit[n]),
            .pend_o   (pend[n]),
            .evt_o    (evt_o[n])
        );
    end

    assign irq_o = pend & irq_en;
endmodule

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for the line controller.
// Inputs change 1 ns after a rising edge; outputs are sampled there too.
module extint_ctrl_tb;
    import extint_pkg::*;

    localparam int NL = 16;
    localparam int NP = 7;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NP*NL-1:0] pins;
    logic           we;
    logic [3:0]     addr;
    logic [15:0]    wdata;
    logic [15:0]    rdata;
    logic [15:0]    irq;
    logic [15:0]    evt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    extint_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_pins (pins),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq),
        .evt_o     (evt)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        step(1);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input string what, input logic [3:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        chk(req, what, rdata, exp);
    endtask

    task automatic pin(input int p, input int l, input logic v);
        pins[p*NL + l] = v;
    endtask

    task automatic cleanup();
        wr(A_IRQ_EN, 16'h0); wr(A_EVT_EN, 16'h0);
        wr(A_RISE, 16'h0);   wr(A_FALL, 16'h0);
        for (int r = 0; r < 4; r++) wr(A_SEL_BASE + 4'(r), 16'h0);
        pins = '0;
        step(4);
        wr(A_PEND, 16'hFFFF);
    endtask

    task automatic t_reset();
        chk("R1", "irq after reset", irq, 16'h0);
        chk("R1", "evt after reset", evt, 16'h0);
        for (int a = 0; a < 12; a++) rd_chk("R1", "register after reset", 4'(a), 16'h0);
    endtask

    task automatic t_readback();
        wr(A_IRQ_EN, 16'hA5A5); rd_chk("R11", "irq enable", A_IRQ_EN, 16'hA5A5);
        wr(A_EVT_EN, 16'h5A5A); rd_chk("R11", "event enable", A_EVT_EN, 16'h5A5A);
        wr(A_RISE, 16'h1234);   rd_chk("R11", "rise enable", A_RISE, 16'h1234);
        wr(A_FALL, 16'h8001);   rd_chk("R11", "fall enable", A_FALL, 16'h8001);
        wr(A_SEL_BASE + 4'd2, 16'h4321); rd_chk("R11", "select reg 10", A_SEL_BASE + 4'd2, 16'h4321);
        cleanup();
    endtask

    task automatic t_rising();
        wr(A_SEL_BASE, 16'h2000);
        wr(A_RISE, 16'h0008); wr(A_IRQ_EN, 16'h0008);
        pin(2, 3, 1'b1);
        step(2); chk("R2", "irq before third edge", irq, 16'h0);
        step(1); chk("R2", "irq at third edge", irq, 16'h0008);
        rd_chk("R2", "pending", A_PEND, 16'h0008);
        wr(A_PEND, 16'h0008);
        pin(2, 3, 1'b0);
        step(5); chk("R3", "falling edge with rise-only", irq, 16'h0);
        cleanup();
    endtask

    task automatic t_falling_both();
        wr(A_FALL, 16'h0020); wr(A_IRQ_EN, 16'h0020);
        pin(0, 5, 1'b1); step(5); chk("R3", "rise with fall-only", irq, 16'h0);
        pin(0, 5, 1'b0); step(3); chk("R3", "fall with fall-only", irq, 16'h0020);
        wr(A_PEND, 16'h0020);
        wr(A_RISE, 16'h0020);
        pin(0, 5, 1'b1); step(3); chk("R3", "rise with both", irq, 16'h0020);
        wr(A_PEND, 16'h0020);
        pin(0, 5, 1'b0); step(3); chk("R3", "fall with both", irq, 16'h0020);
        wr(A_PEND, 16'h0020);
        wr(A_RISE, 16'h0); wr(A_FALL, 16'h0);
        pin(0, 5, 1'b1); step(5); chk("R3", "rise with none", irq, 16'h0);
        rd_chk("R3", "pending with none", A_PEND, 16'h0);
        cleanup();
    endtask

    task automatic t_mask();
        wr(A_RISE, 16'h0002);
        pin(0, 1, 1'b1); step(5);
        chk("R4", "irq with mask off", irq, 16'h0);
        rd_chk("R4", "pending with mask off", A_PEND, 16'h0);
        wr(A_IRQ_EN, 16'h0002);
        chk("R4", "irq after late enable", irq, 16'h0);
        rd_chk("R4", "pending after late enable", A_PEND, 16'h0);
        cleanup();
    endtask

    task automatic t_event();
        wr(A_EVT_EN, 16'h0080); wr(A_RISE, 16'h0080);
        pin(0, 7, 1'b1);
        step(2); chk("R5", "event before third edge", evt, 16'h0);
        step(1); chk("R5", "event at third edge", evt, 16'h0080);
        step(1); chk("R5", "event one cycle later", evt, 16'h0);
        chk("R5", "irq without mask", irq, 16'h0);
        rd_chk("R5", "pending without mask", A_PEND, 16'h0);
        cleanup();
    endtask

    task automatic t_w1c();
        wr(A_IRQ_EN, 16'h0003); wr(A_RISE, 16'h0003);
        pin(0, 0, 1'b1); pin(0, 1, 1'b1);
        step(3); rd_chk("R6", "both pending", A_PEND, 16'h0003);
        wr(A_PEND, 16'h0000); rd_chk("R6", "write zero keeps", A_PEND, 16'h0003);
        wr(A_PEND, 16'h0001); rd_chk("R6", "clear bit 0 only", A_PEND, 16'h0002);
        chk("R6", "irq after partial clear", irq, 16'h0002);
        cleanup();
    endtask

    task automatic t_priority();
        wr(A_RISE, 16'h0200); wr(A_IRQ_EN, 16'h0200);
        pin(0, 9, 1'b1);
        step(2);
        we = 1'b1; addr = A_PEND; wdata = 16'h0200;
        step(1);
        we = 1'b0;
        chk("R7", "edge beats clear", irq, 16'h0200);
        rd_chk("R7", "pending after race", A_PEND, 16'h0200);
        wr(A_PEND, 16'h0200);
        chk("R7", "plain clear after race", irq, 16'h0);
        cleanup();
    endtask

    task automatic t_swtrig();
        wr(A_IRQ_EN, 16'h0400); wr(A_EVT_EN, 16'h0800);
        wr(A_SWTRIG, 16'h0C00);
        chk("R8", "irq from trigger", irq, 16'h0400);
        chk("R8", "event from trigger", evt, 16'h0800);
        rd_chk("R8", "pending from trigger", A_PEND, 16'h0400);
        rd_chk("R8", "trigger reads zero", A_SWTRIG, 16'h0);
        step(1); chk("R8", "trigger event ends", evt, 16'h0);
        cleanup();
    endtask

    task automatic t_select();
        wr(A_SEL_BASE + 4'd1, 16'h0500);
        wr(A_RISE, 16'h0040); wr(A_IRQ_EN, 16'h0040);
        pin(0, 6, 1'b1); step(5); chk("R9", "unselected port ignored", irq, 16'h0);
        pin(5, 7, 1'b1); step(5); chk("R9", "neighbour pin ignored", irq, 16'h0);
        pin(5, 6, 1'b1); step(3); chk("R9", "selected pin seen", irq, 16'h0040);
        wr(A_PEND, 16'h0040);
        wr(A_SEL_BASE + 4'd1, 16'h0700);
        for (int p = 0; p < NP; p++) pin(p, 6, 1'b0);
        step(4);
        for (int p = 0; p < NP; p++) pin(p, 6, 1'b1);
        step(5); chk("R9", "out-of-range select", irq, 16'h0);
        wr(A_SEL_BASE + 4'd3, 16'h6000);
        wr(A_RISE, 16'h8040); wr(A_IRQ_EN, 16'h8040);
        pin(6, 15, 1'b1); step(3); chk("R9", "line 15 on last port", irq, 16'h8000);
        cleanup();
    endtask

    task automatic t_selchange();
        pin(1, 12, 1'b1); step(4);
        wr(A_RISE, 16'h1000); wr(A_FALL, 16'h1000); wr(A_IRQ_EN, 16'h1000);
        wr(A_SEL_BASE + 4'd3, 16'h0001);
        step(5); chk("R10", "no edge from select change", irq, 16'h0);
        pin(1, 12, 1'b0); step(3); chk("R10", "new source edge seen", irq, 16'h1000);
        cleanup();
    endtask

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_readback();
        t_rising();
        t_falling_both();
        t_mask();
        t_event();
        t_w1c();
        t_priority();
        t_swtrig();
        t_select();
        t_selchange();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule